// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This block feeds a transmit byte FIFO from frames held in memory. The frames are described by a ring of two-word descriptors. The engine begins at the first descriptor of the ring when it is enabled. For each descriptor it reads the buffer address and the ownership flag, then the length word. It fetches the buffer one memory word at a time and pushes the bytes into the FIFO in little-endian order, starting at the buffer's byte address. It flags the final byte of each frame.

Once the serial transmitter reports that the frame has gone out, the engine does four things in order:
- it writes a status field into the length word;
- it hands the descriptor back by clearing its ownership flag;
- it pulses a completion interrupt;
- it moves to the next descriptor.

It wraps to the first descriptor after the configured count. A descriptor the engine does not own is either skipped or halts the engine with an interrupt, chosen by a configuration bit.

Top module: `txbd_dma_engine`

## Requirements
- R1: While and directly after reset, mem_req, fifo_wr, fifo_eof, irq_done and irq_halt are all low.
- R2: When cfg_enable rises from the idle state, the first memory request reads the word at cfg_ring_base. Descriptor i sits at cfg_ring_base + 8*i, with word 0 at offset 0 and word 1 at offset 4. A later re-enable restarts at descriptor 0.
- R3: Word 1 bits 15:0 give the frame length N. Exactly N bytes are written to the FIFO. They start at the byte address held in word 0 bits 30:0, which may have any alignment, and byte lane k of a memory word is bits 8k+7:8k.
- R4: fifo_eof is high together with fifo_wr on the last byte of each frame and on no other byte.
- R5: fifo_wr is high only in a cycle whose preceding cycle had fifo_full low.
- R6: After the last byte, the engine waits for a tx_done pulse. It then writes word 1 back: bits 31:18 unchanged, bit 17 = tx_underrun sampled with tx_done, bit 16 = 1 (done), bits 15:0 = the length.
- R7: After the status write, word 0 is rewritten with bit 31 (ownership) cleared and bits 30:0 unchanged. A one-cycle irq_done pulse follows that write.
- R8: With cfg_skip_unowned = 1, a descriptor whose word 0 bit 31 is 0 is passed over. No write goes to it and no interrupt is raised.
- R9: With cfg_skip_unowned = 0, such a descriptor raises a one-cycle irq_halt pulse. No further memory request is made until cfg_enable goes low.
- R10: After descriptor cfg_ring_count-1, the next descriptor read is descriptor 0.
- R11: A length of 0 moves no bytes and does not wait for tx_done. Status is written back with bit 16 set and bit 17 clear, then ownership is cleared and irq_done is pulsed.
- R12: Once raised, mem_req stays high with mem_addr and mem_we stable until the cycle in which mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Run the engine; sampled at descriptor boundaries |
| cfg_skip_unowned | input | 1 | 1 = skip descriptors not owned, 0 = halt on them |
| cfg_ring_base | input | DATA_W | Byte address of descriptor 0 |
| cfg_ring_count | input | IDX_W | Number of descriptors in the ring (at least 1) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | DATA_W | Byte address, word aligned |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Access complete; read data valid this cycle |
| mem_rdata | input | DATA_W | Read data |
| fifo_wr | output | 1 | Byte write strobe to the transmit FIFO |
| fifo_data | output | 8 | Frame byte |
| fifo_eof | output | 1 | Marks the last byte of a frame |
| fifo_full | input | 1 | FIFO cannot take a write in the following cycle |
| tx_done | input | 1 | Transmitter has finished the current frame |
| tx_underrun | input | 1 | Underrun flag, valid with tx_done |
| irq_done | output | 1 | One-cycle pulse per completed descriptor |
| irq_halt | output | 1 | One-cycle pulse when halting on a descriptor not owned |

## Verification
The assertions take for granted that mem_ack only comes while mem_req is high and lasts one cycle, and that tx_done arrives only after the frame's last byte has been pushed. The bench's memory model raises mem_ack on the falling edge after it sees a request and drops it on the next one. The transmitter model pulses tx_done a few cycles after it captures a byte marked end-of-frame. The ring base is kept word aligned, and buffers stay inside the modelled memory, below the ownership bit.

// File: rtl/txbd_pkg.sv
package txbd_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RD_W0,
    S_RD_W1,
    S_RD_DATA,
    S_PUSH,
    S_WAIT_TX,
    S_WR_W1,
    S_WR_W0,
    S_ADV,
    S_HALT
  } eng_state_t;

  // bit positions inside descriptor word 1 (above the length field)
  localparam int unsigned STAT_DONE_OFS  = 0;
  localparam int unsigned STAT_UNDR_OFS  = 1;
  localparam int unsigned STAT_BITS      = 2;
  localparam int unsigned DESC_WORDS     = 2;

endpackage

// File: rtl/txbd_mem_port.sv
module txbd_mem_port #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          we,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          done,
  output logic [DW-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (start && !mem_req) begin
      mem_req   <= 1'b1;
      mem_we    <= we;
      mem_addr  <= addr;
      mem_wdata <= wdata;
    end else if (mem_req && mem_ack) begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
    end
  end

  assign done  = mem_req & mem_ack;
  assign rdata = mem_rdata;

endmodule

// File: rtl/txbd_ring_index.sv
module txbd_ring_index #(
  parameter int unsigned DW    = 32,
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             step,
  input  logic [IDX_W-1:0] count,
  input  logic [DW-1:0]    base,
  output logic [IDX_W-1:0] idx,
  output logic [DW-1:0]    desc_addr
);

  localparam int unsigned BYTES_PER_WORD = DW / 8;
  localparam int unsigned DESC_SHIFT     = $clog2(BYTES_PER_WORD * txbd_pkg::DESC_WORDS);

  logic [IDX_W:0] nxt;
  logic           wrap;

  assign nxt  = {1'b0, idx} + {{IDX_W{1'b0}}, 1'b1};
  assign wrap = (nxt >= {1'b0, count});

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      idx <= '0;
    end else if (step) begin
      idx <= wrap ? '0 : nxt[IDX_W-1:0];
    end
  end

  assign desc_addr = base + (DW'(idx) << DESC_SHIFT);

endmodule

// File: rtl/txbd_dma_engine.sv
module txbd_dma_engine #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic              cfg_skip_unowned,
  input  logic [DATA_W-1:0] cfg_ring_base,
  input  logic [IDX_W-1:0]  cfg_ring_count,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fifo_wr,
  output logic [7:0]        fifo_data,
  output logic              fifo_eof,
  input  logic              fifo_full,
  input  logic              tx_done,
  input  logic              tx_underrun,
  output logic              irq_done,
  output logic              irq_halt
);
  import txbd_pkg::*;

  localparam int unsigned LANES   = DATA_W / 8;
  localparam int unsigned LANE_W  = $clog2(LANES);
  localparam int unsigned OWN_BIT = DATA_W - 1;
  localparam int unsigned CTRL_W  = DATA_W - LEN_W - STAT_BITS;
  localparam logic [DATA_W-1:0] OWN_MASK = DATA_W'(1) << OWN_BIT;

  eng_state_t state;

  logic [DATA_W-1:0] bufp_q;
  logic [DATA_W-1:0] ptr_q;
  logic [DATA_W-1:0] word_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  flen_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              und_q;
  logic              pend_q;

  logic              mem_state;
  logic              mp_start;
  logic              mp_we;
  logic [DATA_W-1:0] mp_addr;
  logic [DATA_W-1:0] mp_wdata;
  logic              mp_done;
  logic [DATA_W-1:0] mp_rdata;

  logic              ring_restart;
  logic              ring_step;
  logic [IDX_W-1:0]  ring_idx;
  logic [DATA_W-1:0] desc_addr;

  logic [LANE_W-1:0] lane;
  logic [7:0]        cur_byte;
  logic              last_byte;
  logic              last_lane;

  txbd_ring_index #(.DW(DATA_W), .IDX_W(IDX_W)) u_ring (
    .clk      (clk),
    .rst      (rst),
    .restart  (ring_restart),
    .step     (ring_step),
    .count    (cfg_ring_count),
    .base     (cfg_ring_base),
    .idx      (ring_idx),
    .desc_addr(desc_addr)
  );

  txbd_mem_port #(.DW(DATA_W)) u_mport (
    .clk      (clk),
    .rst      (rst),
    .start    (mp_start),
    .we       (mp_we),
    .addr     (mp_addr),
    .wdata    (mp_wdata),
    .mem_ack  (mem_ack),
    .mem_rdata(mem_rdata),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .done     (mp_done),
    .rdata    (mp_rdata)
  );

  // access sequencing
  always_comb begin
    mem_state = 1'b0;
    mp_we     = 1'b0;
    mp_addr   = desc_addr;
    mp_wdata  = '0;
    unique case (state)
      S_RD_W0: mem_state = 1'b1;
      S_RD_W1: begin
        mem_state = 1'b1;
        mp_addr   = desc_addr + DATA_W'(LANES);
      end
      S_RD_DATA: begin
        mem_state = 1'b1;
        mp_addr   = {ptr_q[DATA_W-1:LANE_W], {LANE_W{1'b0}}};
      end
      S_WR_W1: begin
        mem_state = 1'b1;
        mp_we     = 1'b1;
        mp_addr   = desc_addr + DATA_W'(LANES);
        mp_wdata  = {ctrl_q, und_q, 1'b1, flen_q};
      end
      S_WR_W0: begin
        mem_state = 1'b1;
        mp_we     = 1'b1;
        mp_wdata  = bufp_q & ~OWN_MASK;
      end
      default: ;
    endcase
  end

  assign mp_start     = mem_state & ~pend_q;
  assign ring_restart = (state == S_IDLE) & cfg_enable;
  assign ring_step    = (state == S_ADV);

  assign lane      = ptr_q[LANE_W-1:0];
  assign cur_byte  = word_q[8*lane +: 8];
  assign last_byte = (len_q == LEN_W'(1));
  assign last_lane = (lane == LANE_W'(LANES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (mp_start) begin
      pend_q <= 1'b1;
    end else if (mp_done) begin
      pend_q <= 1'b0;
    end
  end

  // main sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      bufp_q    <= '0;
      ptr_q     <= '0;
      word_q    <= '0;
      len_q     <= '0;
      flen_q    <= '0;
      ctrl_q    <= '0;
      und_q     <= 1'b0;
      fifo_wr   <= 1'b0;
      fifo_data <= '0;
      fifo_eof  <= 1'b0;
      irq_done  <= 1'b0;
      irq_halt  <= 1'b0;
    end else begin
      fifo_wr  <= 1'b0;
      fifo_eof <= 1'b0;
      irq_done <= 1'b0;
      irq_halt <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (cfg_enable) state <= S_RD_W0;
        end
        S_RD_W0: begin
          if (mp_done) begin
            bufp_q <= mp_rdata;
            ptr_q  <= mp_rdata & ~OWN_MASK;
            if (mp_rdata[OWN_BIT]) begin
              state <= S_RD_W1;
            end else if (cfg_skip_unowned) begin
              state <= S_ADV;
            end else begin
              irq_halt <= 1'b1;
              state    <= S_HALT;
            end
          end
        end
        S_RD_W1: begin
          if (mp_done) begin
            len_q  <= mp_rdata[LEN_W-1:0];
            flen_q <= mp_rdata[LEN_W-1:0];
            ctrl_q <= mp_rdata[DATA_W-1:LEN_W+STAT_BITS];
            und_q  <= 1'b0;
            if (mp_rdata[LEN_W-1:0] == '0) state <= S_WR_W1;
            else                           state <= S_RD_DATA;
          end
        end
        S_RD_DATA: begin
          if (mp_done) begin
            word_q <= mp_rdata;
            state  <= S_PUSH;
          end
        end
        S_PUSH: begin
          if (!fifo_full) begin
            fifo_wr   <= 1'b1;
            fifo_data <= cur_byte;
            fifo_eof  <= last_byte;
            ptr_q     <= ptr_q + DATA_W'(1);
            len_q     <= len_q - LEN_W'(1);
            if (last_byte)      state <= S_WAIT_TX;
            else if (last_lane) state <= S_RD_DATA;
          end
        end
        S_WAIT_TX: begin
          if (tx_done) begin
            und_q <= tx_underrun;
            state <= S_WR_W1;
          end
        end
        S_WR_W1: begin
          if (mp_done) state <= S_WR_W0;
        end
        S_WR_W0: begin
          if (mp_done) begin
            irq_done <= 1'b1;
            state    <= S_ADV;
          end
        end
        S_ADV: begin
          state <= cfg_enable ? S_RD_W0 : S_IDLE;
        end
        S_HALT: begin
          if (!cfg_enable) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/txbd_dma_checker.sv
module txbd_dma_checker #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic [DW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          fifo_wr,
  input logic          fifo_eof,
  input logic          fifo_full,
  input logic          irq_done,
  input logic          irq_halt
);

  a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r5_no_write_after_full: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> !$past(fifo_full));

  a_r4_eof_on_write: assert property (@(posedge clk) disable iff (rst)
    fifo_eof |-> fifo_wr);

  a_r7_done_follows_write: assert property (@(posedge clk) disable iff (rst)
    irq_done |-> $past(mem_req && mem_we && mem_ack));

  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    irq_halt |=> !mem_req);

  a_r7_irq_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(irq_done && irq_halt));

endmodule

bind txbd_dma_engine txbd_dma_checker #(.DW(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_ack  (mem_ack),
  .fifo_wr  (fifo_wr),
  .fifo_eof (fifo_eof),
  .fifo_full(fifo_full),
  .irq_done (irq_done),
  .irq_halt (irq_halt)
);

// File: tb/sim_txbd_dma_engine.sv
`timescale 1ns/1ps
module sim_txbd_dma_engine;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_enable = 1'b0;
  logic        cfg_skip_unowned = 1'b0;
  logic [31:0] cfg_ring_base = '0;
  logic [7:0]  cfg_ring_count = 8'd1;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        fifo_wr, fifo_eof;
  logic [7:0]  fifo_data;
  logic        fifo_full = 1'b0;
  logic        tx_done = 1'b0;
  logic        tx_underrun = 1'b0;
  logic        irq_done, irq_halt;

  always #2.5 clk = ~clk;

  txbd_dma_engine u0 (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_skip_unowned(cfg_skip_unowned),
    .cfg_ring_base(cfg_ring_base), .cfg_ring_count(cfg_ring_count),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_eof(fifo_eof), .fifo_full(fifo_full),
    .tx_done(tx_done), .tx_underrun(tx_underrun), .irq_done(irq_done), .irq_halt(irq_halt)
  );

  int checks = 0;
  int fails  = 0;

  logic [31:0] mem [0:255];
  logic [7:0]  got [0:63];
  logic        goteof [0:63];
  int          nbytes, ndone, nhalt, nreq_cycles, full_viol, txd_cnt, cyc;
  logic [31:0] first_addr;
  logic        seen_first, full_mode, und_cfg;

  // memory, FIFO and transmitter models
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:2]];
    end else begin
      mem_ack <= 1'b0;
    end
    if (mem_req) nreq_cycles <= nreq_cycles + 1;
    if (mem_req && !seen_first) begin
      first_addr <= mem_addr;
      seen_first <= 1'b1;
    end
    if (fifo_wr && fifo_full) full_viol <= full_viol + 1;
    fifo_full <= full_mode && (cyc % 3 == 0);
    if (fifo_wr) begin
      if (nbytes < 64) begin
        got[nbytes]    <= fifo_data;
        goteof[nbytes] <= fifo_eof;
      end
      nbytes <= nbytes + 1;
      if (fifo_eof) txd_cnt <= 4;
    end else if (txd_cnt != 0) begin
      txd_cnt <= txd_cnt - 1;
    end
    tx_done     <= (txd_cnt == 1);
    tx_underrun <= (txd_cnt == 1) && und_cfg;
    if (irq_done) ndone <= ndone + 1;
    if (irq_halt) nhalt <= nhalt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cfg_enable = 1'b0;
    cfg_skip_unowned = 1'b0;
    cfg_ring_base = '0;
    cfg_ring_count = 8'd1;
    full_mode = 1'b0;
    und_cfg = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    nbytes = 0; ndone = 0; nhalt = 0; nreq_cycles = 0; full_viol = 0;
    txd_cnt = 0; seen_first = 1'b0; first_addr = '0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_irq(input int nd, input int nh);
    for (int i = 0; i < 4000; i++) begin
      if (ndone >= nd && nhalt >= nh) break;
      @(negedge clk);
    end
  endtask

  task automatic stop_engine();
    cfg_enable = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(!mem_req && !fifo_wr && !fifo_eof && !irq_done && !irq_halt, "R1 reset outputs",
        {27'd0, mem_req, fifo_wr, fifo_eof, irq_done, irq_halt}, 32'd0);
  endtask

  task automatic t_basic();
    int nreq_at_halt;
    do_reset();
    cfg_ring_base = 32'h20; cfg_ring_count = 8'd2;
    mem[8]  = 32'h8000_0100; mem[9] = 32'hABC0_0005;
    mem[10] = 32'h0000_0200; mem[11] = 32'h0000_0003;
    mem[8'h40] = 32'h4433_2211; mem[8'h41] = 32'h8877_6655;
    cfg_enable = 1'b1;
    wait_irq(1, 1);
    chk(first_addr == 32'h20, "R2 first read at ring base", first_addr, 32'h20);
    chk(nbytes == 5, "R3 byte count", nbytes, 5);
    chk(got[0] == 8'h11 && got[2] == 8'h33 && got[4] == 8'h55, "R3 byte order",
        {8'd0, got[0], got[2], got[4]}, 32'h0011_3355);
    chk(goteof[4] && !goteof[0] && !goteof[3], "R4 end marker on last byte only",
        {29'd0, goteof[0], goteof[3], goteof[4]}, 32'd1);
    chk(mem[9] == 32'hABC1_0005, "R6 status write-back", mem[9], 32'hABC1_0005);
    chk(mem[8] == 32'h0000_0100, "R7 ownership cleared", mem[8], 32'h0000_0100);
    chk(ndone == 1 && nhalt == 1, "R9 halt interrupt on unowned", {ndone[15:0], nhalt[15:0]}, 32'h0001_0001);
    nreq_at_halt = nreq_cycles;
    repeat (40) @(negedge clk);
    chk(nreq_cycles == nreq_at_halt, "R9 no access while halted", nreq_cycles, nreq_at_halt);
    stop_engine();
  endtask

  task automatic t_unaligned_full();
    do_reset();
    cfg_ring_count = 8'd1; full_mode = 1'b1;
    mem[0] = 32'h8000_0103; mem[1] = 32'h0000_0006;
    mem[8'h40] = 32'h4433_2211; mem[8'h41] = 32'h8877_6655; mem[8'h42] = 32'hDDCC_BBAA;
    cfg_enable = 1'b1;
    wait_irq(1, 1);
    chk(nbytes == 6, "R3 unaligned count", nbytes, 6);
    chk({got[0], got[1], got[4], got[5]} == 32'h4455_88AA, "R3 unaligned bytes",
        {got[0], got[1], got[4], got[5]}, 32'h4455_88AA);
    chk(full_viol == 0, "R5 no write after full", full_viol, 0);
    stop_engine();
  endtask

  task automatic t_zero();
    do_reset();
    cfg_ring_count = 8'd1;
    mem[0] = 32'h8000_0100; mem[1] = 32'h0004_0000;
    cfg_enable = 1'b1;
    wait_irq(1, 1);
    chk(nbytes == 0, "R11 zero length moves nothing", nbytes, 0);
    chk(mem[1] == 32'h0005_0000, "R11 zero length status", mem[1], 32'h0005_0000);
    chk(ndone == 1 && mem[0] == 32'h0000_0100, "R11 zero length completes", mem[0], 32'h0000_0100);
    stop_engine();
  endtask

  task automatic t_underrun();
    do_reset();
    cfg_ring_count = 8'd1; und_cfg = 1'b1;
    mem[0] = 32'h8000_0100; mem[1] = 32'h0008_0002;
    mem[8'h40] = 32'h4433_2211;
    cfg_enable = 1'b1;
    wait_irq(1, 1);
    chk(mem[1] == 32'h000B_0002, "R6 underrun in status", mem[1], 32'h000B_0002);
    stop_engine();
  endtask

  task automatic t_skip();
    do_reset();
    cfg_ring_count = 8'd3; cfg_skip_unowned = 1'b1;
    mem[0] = 32'h0000_0300; mem[1] = 32'h0000_0007;
    mem[2] = 32'h0000_0300; mem[3] = 32'h0000_0007;
    mem[4] = 32'h8000_0100; mem[5] = 32'h0000_0001;
    mem[8'h40] = 32'h0000_0077;
    cfg_enable = 1'b1;
    wait_irq(1, 0);
    repeat (100) @(negedge clk);
    chk(nhalt == 0, "R8 no halt when skipping", nhalt, 0);
    chk(nbytes == 1 && got[0] == 8'h77, "R8 owned descriptor after skips", {24'd0, got[0]}, 32'h77);
    chk(mem[1] == 32'h7 && mem[3] == 32'h7 && mem[0] == 32'h300, "R8 skipped descriptors untouched",
        mem[1], 32'h7);
    stop_engine();
    chk(!mem_req, "R8 engine idles after disable", {31'd0, mem_req}, 0);
  endtask

  task automatic t_wrap_restart();
    do_reset();
    cfg_ring_count = 8'd2;
    mem[0] = 32'h8000_0100; mem[1] = 32'h0000_0001;
    mem[2] = 32'h8000_0104; mem[3] = 32'h0000_0001;
    mem[4] = 32'h8000_0108; mem[5] = 32'h0000_0001;
    mem[8'h40] = 32'h0000_0011; mem[8'h41] = 32'h0000_0055; mem[8'h42] = 32'h0000_0099;
    cfg_enable = 1'b1;
    wait_irq(2, 1);
    chk(ndone == 2 && nbytes == 2, "R10 ring wraps after count", {ndone[15:0], nbytes[15:0]}, 32'h0002_0002);
    chk(got[1] == 8'h55 && mem[4] == 32'h8000_0108, "R10 descriptor past ring unused", mem[4], 32'h8000_0108);
    stop_engine();
    mem[0] = 32'h8000_0100;
    cfg_enable = 1'b1;
    wait_irq(3, 2);
    chk(nbytes == 3 && got[2] == 8'h11, "R2 restart at first descriptor", {24'd0, got[2]}, 32'h11);
    stop_engine();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc = 0;
    t_reset();
    t_basic();
    t_unaligned_full();
    t_zero();
    t_underrun();
    t_skip();
    t_wrap_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule